// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 interrupt lines into a bank of parent interrupt outputs. Every line can detect either a level or a rising edge. Every line also has a mask bit, a pending bit, an in-service bit and a one-byte vector. The low bits of the vector byte pick the parent output that the line drives. The block does not OR pending lines together. Instead, each parent output is set by an assertion event and cleared by a deassertion event, and each event services at most one line: the lowest-numbered line that qualifies.

Software reaches the block through a simple little-endian register port made of 64-bit words. An access reads or writes 1, 2, 4 or 8 bytes inside one aligned word. Writes merge only the addressed bytes into the word. Reads shift the word right to the addressed byte and trim it to the access size. Read data is registered.

The block re-evaluates assertion and deassertion when the mask changes. It also does so when software writes the edge-clear register. The two tables, route and vector, each store one byte per line.

Top module: `vec_intc`

## Requirements
- R1: A line with its edge-select bit set (word 0x10, 1 = edge) becomes pending only on a 0-to-1 input change. A falling input leaves it pending, so its in-service bit and its parent output stay set.
- R2: A line with its edge-select bit clear has a pending bit that follows the input. When the input falls, the line becomes a candidate for deassertion.
- R3: On an assertion event, consider the lines that are affected, pending and unmasked. Only the lowest-numbered of these is serviced: its in-service bit is set, and the parent output whose index equals the low log2(NUM_PARENTS) bits of its vector byte goes high. The output changes on the first clock edge after the input change. The upper bits of the vector byte are ignored.
- R4: On a deassertion event, consider the affected lines that are in service but no longer pending. The lowest-numbered of these has its in-service bit cleared, and its vector's parent output goes low.
- R5: A write to the mask word (0x08, 1 = masked) merges bytes into the mask. Bits that become unmasked are handled as an assertion event. Bits that become masked are handled as a deassertion event, so a masked line that is still pending keeps its parent output high.
- R6: A write to the clear word (0x30) acts only on written bits whose line is in edge mode. For those lines it clears the pending bit, runs deassertion, and clears the in-service bit. For level-mode lines the write has no effect.
- R7: The status word (0x38) reads as in-service AND NOT mask.
- R8: A read takes two fields. The byte offset is addr[2:0]. The size code is bus_size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The read returns the word shifted right by 8 × offset and masked to the size, one cycle after bus_rd. bus_rdata is zero after a cycle with no read.
- R9: A write replaces only the addressed bytes of the word and keeps the others. Data bits above the access size are ignored. Words 0x18 and 0x40 are plain read/write storage.
- R10: The route table (0x80–0xBF) and the vector table (0xC0–0xFF) hold one byte per line, with line i at base + i. Both tables can be read and written at any access size.
- R11: Word 0x00 reads as the ID_VALUE parameter. Reads of the following words return zero: 0x20 and 0x28, which also discard writes; 0x30; and the unmapped words 0x48–0x7F.
- R12: After reset the mask is all ones. Every other register, every table, every parent output and bus_rdata are zero.
- R13: When an input change and a bus write fall in the same cycle, the input change is applied first. It is evaluated against the old mask, and then the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Interrupt line inputs |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 64 | Write data, right-aligned |
| bus_rdata | output | 64 | Registered read data |
| parent_irq | output | NUM_PARENTS | Parent interrupt outputs |

## Verification
An input edge on a line and a bus write to the mask or clear register can land in the same clock cycle. The bench provokes this in two ways. First, it raises a level line in the same cycle as a mask write that masks it; the line must still be serviced, because it is evaluated against the old mask. Second, it raises an edge line in the same cycle as a clear write to that line; the line's parent output must end the cycle low and its status must be zero. Each case is judged at the parent outputs one cycle later and through a status read.

// File: rtl/pic_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Assumes 64 lines and 64-bit register words, with an 8-bit byte address.
package pic_pkg;
    localparam int WORD_W    = 64;
    localparam int LINES     = 64;
    localparam int ADDR_W    = 8;
    localparam int TAB_WORDS = LINES / 8;

    // Register word indices (byte address divided by 8)
    localparam logic [4:0] W_ID     = 5'd0;
    localparam logic [4:0] W_MASK   = 5'd1;
    localparam logic [4:0] W_EDGE   = 5'd2;
    localparam logic [4:0] W_ENABLE = 5'd3;
    localparam logic [4:0] W_AUTO0  = 5'd4;
    localparam logic [4:0] W_AUTO1  = 5'd5;
    localparam logic [4:0] W_CLEAR  = 5'd6;
    localparam logic [4:0] W_STATUS = 5'd7;
    localparam logic [4:0] W_POL    = 5'd8;

    // Table regions selected by address bits [7:6]
    localparam logic [1:0] REGION_ROUTE = 2'b10;
    localparam logic [1:0] REGION_VEC   = 2'b11;

    typedef enum logic [1:0] {ACC_1B, ACC_2B, ACC_4B, ACC_8B} acc_size_e;

    // Right-aligned field mask for one access size
    function automatic logic [WORD_W-1:0] size_field(input acc_size_e s);
        case (s)
            ACC_1B:  return 64'h0000_0000_0000_00FF;
            ACC_2B:  return 64'h0000_0000_0000_FFFF;
            ACC_4B:  return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/pic_bus_lanes.sv
// Byte-lane steering for the register port.
// Produces the byte-lane write mask, the write data shifted to its lanes,
// and the read value shifted down and trimmed. Assumes aligned accesses.
module pic_bus_lanes import pic_pkg::*; (
    input  logic [2:0]        byte_off,
    input  logic [1:0]        acc_size,
    input  logic [WORD_W-1:0] wr_value,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] lane_mask,
    output logic [WORD_W-1:0] lane_data,
    output logic [WORD_W-1:0] rd_value
);
    logic [WORD_W-1:0] field;
    logic [5:0]        shamt;

    // Shift the size field and data to the addressed byte lanes
    always_comb begin
        field     = size_field(acc_size_e'(acc_size));
        shamt     = {byte_off, 3'b000};
        lane_mask = field << shamt;
        lane_data = (wr_value & field) << shamt;
        rd_value  = (rd_word >> shamt) & field;
    end
endmodule

// File: rtl/pic_line_track.sv
// Per-line input history and pending state.
// Edge-mode lines latch a rising input; level-mode lines follow the input.
// pend_in is the pending state after the input change only; pend_nx also
// applies the clear bits (already restricted to edge-mode lines).
module pic_line_track #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall,
    output logic [N-1:0] pend_in,
    output logic [N-1:0] pend_nx
);
    logic [N-1:0] last_q;
    logic [N-1:0] pend_q;

    // Detect changes and compute pending from the detection mode
    always_comb begin
        rise    = irq_in & ~last_q;
        fall    = ~irq_in & last_q;
        pend_in = (edge_mode & (pend_q | rise)) | (~edge_mode & irq_in);
        pend_nx = pend_in & ~clr_bits;
    end

    // Store the last input level and the pending bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            pend_q <= '0;
        end else begin
            last_q <= irq_in;
            pend_q <= pend_nx;
        end
    end
endmodule

// File: rtl/pic_lowest_pick.sv
// Finds the lowest set bit of a request vector.
// Purely combinational; idx is zero when nothing is requested.
module pic_lowest_pick #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vec_intc.sv
// Vectored interrupt controller top.
// Holds the register file and tables, handles one assertion and one
// deassertion per cycle (lowest line wins), and drives the registered parent
// outputs. Assumes NUM_PARENTS is between 2 and 128 and accesses are aligned.
// An input change is evaluated before a bus write in the same cycle.
module vec_intc import pic_pkg::*; #(
    parameter int NUM_PARENTS = 16,
    parameter logic [WORD_W-1:0] ID_VALUE = 64'h0001_0040_0000_0007,
    localparam int PAR_W = $clog2(NUM_PARENTS),
    localparam int LW    = $clog2(LINES),
    localparam int TW    = $clog2(TAB_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LINES-1:0]       irq_in,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [1:0]             bus_size,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    output logic [NUM_PARENTS-1:0] parent_irq
);
    logic [WORD_W-1:0] mask_q, edge_q, enable_q, pol_q, isr_q;
    logic [WORD_W-1:0] route_q [TAB_WORDS];
    logic [WORD_W-1:0] vec_q   [TAB_WORDS];
    logic [WORD_W-1:0] rdata_q;
    logic [NUM_PARENTS-1:0] parent_q, parent_nx;

    logic [4:0]        word_idx;
    logic [TW-1:0]     tab_idx;
    logic              in_route, in_vec, wr_reg;
    logic [WORD_W-1:0] lane_mask, lane_data, rd_value, rd_word;
    logic [WORD_W-1:0] mask_nx, clr_bits, unmasked, newly_masked;
    logic [LINES-1:0]  rise, fall, pend_in, pend_nx;
    logic [LINES-1:0]  a_req, d_req, a_hot, d_hot, isr_mid, isr_nx;
    logic              a_found, d_found, a_via_bus;
    logic [LW-1:0]     a_idx, d_idx;
    logic [7:0]        a_vec, d_vec;
    logic [PAR_W-1:0]  a_par, d_par;
    logic              unused_vec_hi;

    // Merge addressed lanes into an old word
    function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old,
                                                input logic [WORD_W-1:0] m,
                                                input logic [WORD_W-1:0] d);
        return (old & ~m) | d;
    endfunction

    // Vector byte of one line
    function automatic logic [7:0] vec_of(input logic [LW-1:0] idx);
        return vec_q[idx[LW-1:3]][{idx[2:0], 3'b000} +: 8];
    endfunction

    assign word_idx = bus_addr[7:3];
    assign tab_idx  = bus_addr[5:3];
    assign in_route = (bus_addr[7:6] == REGION_ROUTE);
    assign in_vec   = (bus_addr[7:6] == REGION_VEC);
    assign wr_reg   = bus_wr && !in_route && !in_vec;

    pic_bus_lanes u_lanes (
        .byte_off  (bus_addr[2:0]),
        .acc_size  (bus_size),
        .wr_value  (bus_wdata),
        .rd_word   (rd_word),
        .lane_mask (lane_mask),
        .lane_data (lane_data),
        .rd_value  (rd_value)
    );

    // Select the word addressed by a read
    always_comb begin
        rd_word = '0;
        if (in_route)    rd_word = route_q[tab_idx];
        else if (in_vec) rd_word = vec_q[tab_idx];
        else begin
            case (word_idx)
                W_ID:     rd_word = ID_VALUE;
                W_MASK:   rd_word = mask_q;
                W_EDGE:   rd_word = edge_q;
                W_ENABLE: rd_word = enable_q;
                W_STATUS: rd_word = isr_q & ~mask_q;
                W_POL:    rd_word = pol_q;
                default:  rd_word = '0;
            endcase
        end
    end

    // Mask change and edge-clear bits caused by this cycle's write
    always_comb begin
        mask_nx      = (wr_reg && word_idx == W_MASK) ? merge(mask_q, lane_mask, lane_data) : mask_q;
        clr_bits     = (wr_reg && word_idx == W_CLEAR) ? (lane_data & edge_q) : '0;
        unmasked     = mask_q & ~mask_nx;
        newly_masked = ~mask_q & mask_nx;
    end

    pic_line_track #(.N(LINES)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .edge_mode (edge_q),
        .clr_bits  (clr_bits),
        .rise      (rise),
        .fall      (fall),
        .pend_in   (pend_in),
        .pend_nx   (pend_nx)
    );

    assign a_req = ((rise & ~mask_q) | unmasked) & pend_in;

    pic_lowest_pick #(.W(LINES)) u_pick_assert (
        .req   (a_req),
        .found (a_found),
        .idx   (a_idx)
    );

    // In-service after the assertion, then deassertion candidates
    always_comb begin
        a_hot   = a_found ? (LINES'(1) << a_idx) : '0;
        isr_mid = isr_q | a_hot;
        d_req   = (fall | newly_masked | clr_bits) & isr_mid & ~pend_nx;
    end

    pic_lowest_pick #(.W(LINES)) u_pick_deassert (
        .req   (d_req),
        .found (d_found),
        .idx   (d_idx)
    );

    // Final in-service bits and parent selection of both events
    always_comb begin
        d_hot     = d_found ? (LINES'(1) << d_idx) : '0;
        isr_nx    = isr_mid & ~d_hot & ~clr_bits;
        a_vec     = vec_of(a_idx);
        d_vec     = vec_of(d_idx);
        a_par     = a_vec[PAR_W-1:0];
        d_par     = d_vec[PAR_W-1:0];
        a_via_bus = !(rise[a_idx] && !mask_q[a_idx]);
    end
    assign unused_vec_hi = ^{a_vec[7:PAR_W], d_vec[7:PAR_W]};

    // Per-parent update; the event from the bus write is applied last
    for (genvar j = 0; j < NUM_PARENTS; j++) begin : g_parent
        logic set_j, clr_j;
        assign set_j = a_found && (a_par == PAR_W'(j));
        assign clr_j = d_found && (d_par == PAR_W'(j));
        assign parent_nx[j] = a_via_bus ? ((parent_q[j] & ~clr_j) | set_j)
                                        : ((parent_q[j] | set_j) & ~clr_j);
    end

    // Register file, in-service, parent outputs and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '1;
            edge_q   <= '0;
            enable_q <= '0;
            pol_q    <= '0;
            isr_q    <= '0;
            parent_q <= '0;
            rdata_q  <= '0;
            for (int k = 0; k < TAB_WORDS; k++) begin
                route_q[k] <= '0;
                vec_q[k]   <= '0;
            end
        end else begin
            mask_q   <= mask_nx;
            isr_q    <= isr_nx;
            parent_q <= parent_nx;
            rdata_q  <= bus_rd ? rd_value : '0;
            if (wr_reg && word_idx == W_EDGE)   edge_q   <= merge(edge_q, lane_mask, lane_data);
            if (wr_reg && word_idx == W_ENABLE) enable_q <= merge(enable_q, lane_mask, lane_data);
            if (wr_reg && word_idx == W_POL)    pol_q    <= merge(pol_q, lane_mask, lane_data);
            for (int k = 0; k < TAB_WORDS; k++) begin
                if (bus_wr && in_route && tab_idx == TW'(k))
                    route_q[k] <= merge(route_q[k], lane_mask, lane_data);
                if (bus_wr && in_vec && tab_idx == TW'(k))
                    vec_q[k] <= merge(vec_q[k], lane_mask, lane_data);
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign parent_irq = parent_q;
endmodule

// File: rtl/pic_checker.sv
// Assertion checker for vec_intc, attached by bind.
// Observes in-service and mask state together with the bus and outputs.
// Checks start one cycle after reset has released.
module pic_checker import pic_pkg::*; #(
    parameter int NUM_PARENTS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [WORD_W-1:0]      isr_q,
    input logic [WORD_W-1:0]      mask_q,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [1:0]             bus_size,
    input logic [WORD_W-1:0]      bus_rdata,
    input logic [NUM_PARENTS-1:0] parent_irq
);
    logic seen_q;

    // Marks that at least one cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_SINGLE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $countones(isr_q & ~$past(isr_q)) <= 1) else $error("two lines serviced at once"); // R3

    AST_MASKED_NOT_SERVICED: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (isr_q & ~$past(isr_q) & $past(mask_q) & mask_q) == '0) else $error("masked line serviced"); // R5

    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        !$past(bus_wr && bus_addr[7:3] == W_CLEAR) |-> $countones($past(isr_q) & ~isr_q) <= 1)
        else $error("two lines retired without clear"); // R4

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        bus_rd && bus_addr == {W_STATUS, 3'b000} && bus_size == 2'd3 |=> bus_rdata == $past(isr_q & ~mask_q))
        else $error("status read mismatch"); // R7

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        !bus_rd |=> bus_rdata == '0) else $error("read data not zero when idle"); // R8

    // Parent outputs are observed only at the ports by the bench
    logic unused_parent;
    assign unused_parent = ^parent_irq;
endmodule

bind vec_intc pic_checker #(.NUM_PARENTS(NUM_PARENTS)) u_pic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .isr_q      (isr_q),
    .mask_q     (mask_q),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_size   (bus_size),
    .bus_rdata  (bus_rdata),
    .parent_irq (parent_irq)
);

// File: tb/test_vec_intc.sv
`timescale 1ns/1ps
// Self-checking bench for vec_intc: sweeps byte lanes, tables and every line.
module test_vec_intc;
    localparam int NP = 16;
    localparam logic [63:0] ID = 64'h1234_5678_9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [NP-1:0] parent_irq;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vec_intc #(.NUM_PARENTS(NP), .ID_VALUE(ID)) i_vec_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .parent_irq(parent_irq));

    function automatic logic [7:0] vbyte(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction
    function automatic logic [NP-1:0] pbit(input int i);
        return NP'(1) << (vbyte(i) & 8'h0F);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [1:0] sz, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        irq[i] = v;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [63:0] rd, model, fld, d, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 parent", 64'(parent_irq), 0);
        check("R12 rdata", bus_rdata, 0);
        bus_read(8'h08, 2'd3, rd); check("R12 mask", rd, '1);
        bus_read(8'h10, 2'd3, rd); check("R12 edge", rd, 0);
        bus_read(8'h38, 2'd3, rd); check("R12 status", rd, 0);
        bus_read(8'hC0, 2'd3, rd); check("R12 vector", rd, 0);

        // R8, R9: byte-lane sweep on plain storage word
        model = '0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 8; off += (1 << sz)) begin
                fld = (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 1);
                d = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(sz * 8 + off) * 64'h0101_0101_0101_0101);
                bus_write(8'(8'h40 + off), 2'(sz), d);
                model = (model & ~(fld << (off * 8))) | ((d & fld) << (off * 8));
                bus_read(8'h40, 2'd3, rd); check("R9 merge", rd, model);
                bus_read(8'(8'h40 + off), 2'(sz), rd); check("R8 subread", rd, (model >> (off * 8)) & fld);
            end
        end
        bus_write(8'h1A, 2'd1, 64'hFFFF_FFFF_FFFF_BEEF);
        bus_read(8'h18, 2'd3, rd); check("R9 enable word", rd, 64'h0000_0000_BEEF_0000);
        @(negedge clk); check("R8 idle rdata", bus_rdata, 0);

        // R10: vector table by bytes, route table by 4-byte writes
        for (int i = 0; i < 64; i++) bus_write(8'(8'hC0 + i), 2'd0, {56'hABCDEF_0123_4567, vbyte(i)});
        for (int k = 0; k < 8; k++) begin
            w = '0;
            for (int b = 0; b < 8; b++) w[b*8 +: 8] = vbyte(k * 8 + b);
            bus_read(8'(8'hC0 + k * 8), 2'd3, rd); check("R10 vector word", rd, w);
        end
        for (int k = 0; k < 8; k++) begin
            w = '0;
            for (int b = 0; b < 8; b++) w[b*8 +: 8] = 8'(k * 8 + b) ^ 8'h5A;
            bus_write(8'(8'h80 + k * 8), 2'd2, w);
            bus_write(8'(8'h84 + k * 8), 2'd2, w >> 32);
            for (int h = 0; h < 4; h++) begin
                bus_read(8'(8'h80 + k * 8 + h * 2), 2'd1, rd);
                check("R10 route half", rd, (w >> (h * 16)) & 64'hFFFF);
            end
        end

        // R11: ID, auto-control, clear and unmapped words
        bus_read(8'h00, 2'd3, rd); check("R11 id", rd, ID);
        bus_read(8'h04, 2'd2, rd); check("R11 id upper", rd, ID >> 32);
        bus_write(8'h20, 2'd3, '1);
        bus_read(8'h20, 2'd3, rd); check("R11 auto0", rd, 0);
        bus_write(8'h28, 2'd3, '1);
        bus_read(8'h28, 2'd3, rd); check("R11 auto1", rd, 0);
        bus_read(8'h30, 2'd3, rd); check("R11 clear reads zero", rd, 0);
        bus_read(8'h48, 2'd3, rd); check("R11 unmapped 48", rd, 0);
        bus_read(8'h78, 2'd3, rd); check("R11 unmapped 78", rd, 0);

        // R2, R3, R4, R7: every line in level mode
        bus_write(8'h08, 2'd3, 64'h0);
        for (int i = 0; i < 64; i++) begin
            set_line(i, 1'b1);
            check("R3 level assert parent", 64'(parent_irq), 64'(pbit(i)));
            bus_read(8'h38, 2'd3, rd); check("R7 status", rd, 64'd1 << i);
            set_line(i, 1'b0);
            check("R2 level fall parent", 64'(parent_irq), 0);
        end
        bus_read(8'h38, 2'd3, rd); check("R4 status after sweep", rd, 0);

        // R3: lowest-numbered of two simultaneous lines
        @(negedge clk); irq[5] = 1'b1; irq[9] = 1'b1;
        @(negedge clk); check("R3 lowest wins", 64'(parent_irq), 64'(pbit(5)));
        bus_read(8'h38, 2'd3, rd); check("R3 lowest status", rd, 64'd1 << 5);
        set_line(5, 1'b0); check("R4 retire lowest", 64'(parent_irq), 0);
        set_line(9, 1'b0); check("R4 unserviced fall", 64'(parent_irq), 0);

        // R1, R6: edge mode keeps pending after fall; clear retires
        bus_write(8'h10, 2'd3, '1);
        set_line(3, 1'b1); check("R1 edge rise", 64'(parent_irq), 64'(pbit(3)));
        set_line(3, 1'b0); check("R1 edge fall keeps", 64'(parent_irq), 64'(pbit(3)));
        bus_read(8'h38, 2'd3, rd); check("R1 status kept", rd, 64'd1 << 3);
        bus_write(8'h30, 2'd0, 64'h08); check("R6 clear edge", 64'(parent_irq), 0);
        bus_read(8'h38, 2'd3, rd); check("R6 status cleared", rd, 0);

        // R6: clear has no effect on a level line
        bus_write(8'h10, 2'd3, ~(64'd1 << 10));
        set_line(10, 1'b1); check("R3 line10", 64'(parent_irq), 64'(pbit(10)));
        bus_write(8'h30, 2'd1, 64'h0400); check("R6 level ignores clear", 64'(parent_irq), 64'(pbit(10)));
        bus_read(8'h38, 2'd3, rd); check("R6 level status kept", rd, 64'd1 << 10);
        set_line(10, 1'b0); check("R2 line10 fall", 64'(parent_irq), 0);

        // R5: mask writes re-run assertion and deassertion
        bus_write(8'h10, 2'd3, 64'h0);
        bus_write(8'h08, 2'd3, '1);
        set_line(20, 1'b1); check("R5 masked no assert", 64'(parent_irq), 0);
        bus_write(8'h0A, 2'd0, 64'hEF); check("R5 unmask asserts", 64'(parent_irq), 64'(pbit(20)));
        bus_read(8'h38, 2'd3, rd); check("R5 status after unmask", rd, 64'd1 << 20);
        bus_write(8'h0A, 2'd0, 64'hFF); check("R5 remask keeps pending", 64'(parent_irq), 64'(pbit(20)));
        bus_read(8'h38, 2'd3, rd); check("R7 masked status", rd, 0);
        set_line(20, 1'b0); check("R4 fall retires", 64'(parent_irq), 0);
        @(negedge clk); irq[30] = 1'b1; irq[40] = 1'b1;
        @(negedge clk); check("R5 both masked", 64'(parent_irq), 0);
        bus_write(8'h08, 2'd3, ~((64'd1 << 30) | (64'd1 << 40)));
        check("R5 unmask lowest", 64'(parent_irq), 64'(pbit(30)));
        bus_read(8'h38, 2'd3, rd); check("R5 unmask status", rd, 64'd1 << 30);
        set_line(30, 1'b0); check("R4 line30 retire", 64'(parent_irq), 0);
        bus_write(8'h08, 2'd3, '1);
        bus_write(8'h08, 2'd3, ~(64'd1 << 40)); check("R5 second unmask", 64'(parent_irq), 64'(pbit(40)));
        set_line(40, 1'b0); check("R4 line40 retire", 64'(parent_irq), 0);

        // R13: input change and mask write in one cycle
        bus_write(8'h08, 2'd3, 64'h0);
        @(negedge clk);
        irq[50] = 1'b1;
        bus_addr = 8'h08; bus_size = 2'd3; bus_wdata = 64'd1 << 50; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        check("R13 input before mask", 64'(parent_irq), 64'(pbit(50)));
        bus_read(8'h38, 2'd3, rd); check("R13 masked status", rd, 0);
        set_line(50, 1'b0); check("R13 retire after", 64'(parent_irq), 0);

        // R13: edge rise and clear write in one cycle
        bus_write(8'h08, 2'd3, 64'h0);
        bus_write(8'h10, 2'd3, '1);
        @(negedge clk);
        irq[51] = 1'b1;
        bus_addr = 8'h30; bus_size = 2'd3; bus_wdata = 64'd1 << 51; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        check("R13 rise then clear", 64'(parent_irq), 0);
        bus_read(8'h38, 2'd3, rd); check("R13 clear status", rd, 0);
        set_line(51, 1'b0); check("R1 fall after clear", 64'(parent_irq), 0);
        set_line(51, 1'b1); check("R1 new rise", 64'(parent_irq), 64'(pbit(51)));
        bus_write(8'h36, 2'd0, 64'h08); check("R6 clear byte lane", 64'(parent_irq), 0);

        summary();
    end
endmodule